// File: doc/BRIEF.md
# Lift Usage Cycle Counter with Alarm Tone

This block sits beside a two-level service-lift controller and records how often the car completes a round trip. A round trip is leaving level 0, reaching level 1 and coming back to level 0. The controller reports each finished trip with a one-clock strobe. The block keeps the tally as two BCD digits, from 0 to 99, and drives two seven-segment patterns. The segment polarity is chosen by a parameter.

When the hundredth trip arrives, the block emits a single-clock overflow pulse and the tally returns to zero. The same pulse starts an audible burst: a square wave of about 1.3 kHz on one pin for about 2.5 s, after which the pin rests low. Both the tone half-period and the burst length are timed by counters that advance only on a reference-rate clock enable (50 MHz by default). Their divider values are parameters. An overflow that arrives while a burst is still sounding restarts the burst timer.

Top module: `lift_usage_counter`

## Requirements
- R1: While reset is held, and after it is released, both digits show 0, ovf_pulse is low and tone_out is low.
- R2: Each clock with cycle_done high adds one to the tally. The ones digit goes from 9 to 0 and carries into the tens digit.
- R3: In a clock with cycle_done low, the tally does not change.
- R4: A strobe that arrives when the tally is 99 returns both digits to 0 at that clock edge. The same edge raises ovf_pulse, which stays high for exactly one clock.
- R5: The clock after ovf_pulse, the tone starts low. tone_out then toggles after every HALF_DIV reference ticks, so every high phase lasts HALF_DIV ticks.
- R6: A burst lasts BURST_HALVES half-periods from its start. It then forces tone_out low, and tone_out stays low until the next overflow.
- R7: An overflow during an active burst restarts the burst. The tone phase and the half-period count go back to zero, and the full length is measured again from the new pulse.
- R8: The tone timers advance only in clocks with ref_tick high. While ref_tick is low, tone_out holds its value and the end of the burst moves later by the same number of clocks.
- R9: Segment bits are ordered g,f,e,d,c,b,a from bit 6 down to bit 0. The lit segments for digits 0 to 9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F in hex. With SEG_ACTIVE_LOW=1 the outputs are the bitwise inverse of these values.
- R10: Pulling rst_n low at any time, including during a burst, clears the tally and drives tone_out low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; takes effect at once and is released on a clock edge |
| ref_tick | input | 1 | Reference-rate clock enable for the tone timers |
| cycle_done | input | 1 | One-clock strobe for each completed round trip |
| seg_tens | output | 7 | Seven-segment pattern for the tens digit |
| seg_ones | output | 7 | Seven-segment pattern for the ones digit |
| ovf_pulse | output | 1 | One-clock pulse on the hundredth trip |
| tone_out | output | 1 | Square-wave tone output |

## Verification
The assertions treat cycle_done as a plain level, sampled every clock, that the controller holds low during reset and during the two clocks it takes to release reset. The timing assertion on the tone assumes that ref_tick is a clean enable, sampled on the same clock. The stimulus changes every input only on falling clock edges and keeps cycle_done low until at least five clocks after reset is released. It drives ref_tick high throughout, except for one deliberate gap that tests the hold behaviour. The bench overrides the divider parameters so that bursts last a few hundred clocks and still end inside a short run.

// File: rtl/lift_usage_pkg.sv
package lift_usage_pkg;
  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  // Lit-segment pattern, bit 6 = g ... bit 0 = a
  function automatic seg_t bcd_to_seg(input bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/trip_bcd_counter.sv
module trip_bcd_counter
  import lift_usage_pkg::*;
#(
  parameter int MAX_COUNT = 99
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output bcd_t tens,
  output bcd_t ones,
  output logic wrap
);
  localparam bcd_t TOP_TENS = bcd_t'(MAX_COUNT / 10);
  localparam bcd_t TOP_ONES = bcd_t'(MAX_COUNT % 10);

  bcd_t tens_q, ones_q, tens_d, ones_d;
  logic wrap_q, wrap_d;

  always_comb begin
    tens_d = tens_q;
    ones_d = ones_q;
    wrap_d = 1'b0;
    if (inc) begin
      if (tens_q == TOP_TENS && ones_q == TOP_ONES) begin
        tens_d = '0;
        ones_d = '0;
        wrap_d = 1'b1;
      end else if (ones_q == 4'd9) begin
        ones_d = '0;
        tens_d = tens_q + 4'd1;
      end else begin
        ones_d = ones_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens_q <= '0;
      ones_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      tens_q <= tens_d;
      ones_q <= ones_d;
      wrap_q <= wrap_d;
    end
  end

  assign tens = tens_q;
  assign ones = ones_q;
  assign wrap = wrap_q;
endmodule

// File: rtl/seg_digit_decoder.sv
module seg_digit_decoder
  import lift_usage_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  bcd_t digit,
  output seg_t seg
);
  seg_t lit;

  always_comb lit = bcd_to_seg(digit);

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
    end else begin : g_high
      assign seg = lit;
    end
  endgenerate
endmodule

// File: rtl/tone_burst_gen.sv
module tone_burst_gen #(
  parameter int HALF_DIV     = 19231,
  parameter int BURST_HALVES = 6500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic tone
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = (BURST_HALVES > 1) ? $clog2(BURST_HALVES) : 1;
  localparam logic [HW-1:0] HALF_LAST  = HW'(HALF_DIV - 1);
  localparam logic [BW-1:0] BURST_LAST = BW'(BURST_HALVES - 1);

  logic [HW-1:0] half_q, half_d;
  logic [BW-1:0] nhalf_q, nhalf_d;
  logic          act_q, act_d;
  logic          tone_q, tone_d;

  always_comb begin
    half_d  = half_q;
    nhalf_d = nhalf_q;
    act_d   = act_q;
    tone_d  = tone_q;
    if (start) begin
      act_d   = 1'b1;
      half_d  = '0;
      nhalf_d = '0;
      tone_d  = 1'b0;
    end else if (act_q && tick) begin
      if (half_q == HALF_LAST) begin
        half_d = '0;
        if (nhalf_q == BURST_LAST) begin
          act_d   = 1'b0;
          tone_d  = 1'b0;
          nhalf_d = '0;
        end else begin
          nhalf_d = nhalf_q + 1'b1;
          tone_d  = ~tone_q;
        end
      end else begin
        half_d = half_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= '0;
      nhalf_q <= '0;
      act_q   <= 1'b0;
      tone_q  <= 1'b0;
    end else begin
      half_q  <= half_d;
      nhalf_q <= nhalf_d;
      act_q   <= act_d;
      tone_q  <= tone_d;
    end
  end

  assign tone = tone_q;
endmodule

// File: rtl/lift_usage_counter.sv
module lift_usage_counter
  import lift_usage_pkg::*;
#(
  parameter int MAX_COUNT      = 99,
  parameter bit SEG_ACTIVE_LOW = 1'b1,
  parameter int HALF_DIV       = 19231,
  parameter int BURST_HALVES   = 6500,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       cycle_done,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_ones,
  output logic       ovf_pulse,
  output logic       tone_out
);
  localparam int NDIG = 2;

  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_sync_n;
  bcd_t                   tens_d, ones_d;
  bcd_t [NDIG-1:0]        digs;
  seg_t [NDIG-1:0]        segs;

  // asynchronous assert, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rsync_q[SYNC_STAGES-1];

  trip_bcd_counter #(.MAX_COUNT(MAX_COUNT)) u_cnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .inc  (cycle_done),
    .tens (tens_d),
    .ones (ones_d),
    .wrap (ovf_pulse)
  );

  tone_burst_gen #(.HALF_DIV(HALF_DIV), .BURST_HALVES(BURST_HALVES)) u_tone (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .tick (ref_tick),
    .start(ovf_pulse),
    .tone (tone_out)
  );

  assign digs[0] = ones_d;
  assign digs[1] = tens_d;

  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
      seg_digit_decoder #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_dec (
        .digit(digs[g]),
        .seg  (segs[g])
      );
    end
  endgenerate

  assign seg_ones = segs[0];
  assign seg_tens = segs[1];
endmodule

// File: rtl/lift_usage_chk.sv
module lift_usage_chk (
  input logic       clk,
  input logic       rst_ok_n,
  input logic       cycle_done,
  input logic       ref_tick,
  input logic       ovf_pulse,
  input logic       tone_out,
  input logic [3:0] tens,
  input logic [3:0] ones
);
  logic [6:0] tally;
  assign tally = 7'(tens) * 7'd10 + 7'(ones);

  // R2
  digits_range_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (tens <= 4'd9) && (ones <= 4'd9));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (cycle_done && tally != 7'd99) |=> (tally == $past(tally) + 7'd1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !cycle_done |=> $stable(tally));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ovf_pulse |-> (tally == 7'd0 && $past(cycle_done)));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ovf_pulse |=> !ovf_pulse);

  // R8
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $rose(tone_out) |-> $past(ref_tick));

  // R5
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ovf_pulse |=> !tone_out);
endmodule

bind lift_usage_counter lift_usage_chk u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .cycle_done(cycle_done),
  .ref_tick  (ref_tick),
  .ovf_pulse (ovf_pulse),
  .tone_out  (tone_out),
  .tens      (tens_d),
  .ones      (ones_d)
);

// File: tb/sim_lift_usage_counter.sv
`timescale 1ns/1ps
module sim_lift_usage_counter;
  localparam int HD = 4;
  localparam int BH = 60;
  localparam int BURST_CLKS = HD * BH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b1;
  logic cycle_done = 1'b0;
  logic [6:0] seg_tens, seg_ones, segh_tens, segh_ones;
  logic ovf_pulse, tone_out, ovf_h, tone_h;

  int n_chk = 0;
  int n_fail = 0;
  int model = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lift_usage_counter #(.HALF_DIV(HD), .BURST_HALVES(BH), .SEG_ACTIVE_LOW(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cycle_done(cycle_done),
    .seg_tens(seg_tens), .seg_ones(seg_ones), .ovf_pulse(ovf_pulse), .tone_out(tone_out));

  lift_usage_counter #(.HALF_DIV(HD), .BURST_HALVES(BH), .SEG_ACTIVE_LOW(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cycle_done(cycle_done),
    .seg_tens(segh_tens), .seg_ones(segh_ones), .ovf_pulse(ovf_h), .tone_out(tone_h));

  function automatic logic [6:0] lit(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // display must match model count (active-low outputs on u0)
  task automatic chk_disp(input string req);
    logic [6:0] et, eo;
    et = ~lit(model / 10);
    eo = ~lit(model % 10);
    chk(seg_tens == et && seg_ones == eo, req, {seg_tens, seg_ones}, {et, eo});
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // hold cycle_done for n clocks; returns number of ovf pulses seen
  task automatic strobes(input int n, output int novf);
    novf = 0;
    @(negedge clk) cycle_done = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ovf_pulse) novf++;
      model = (model + 1) % 100;
    end
    cycle_done = 1'b0;
  endtask

  // after an ovf negedge: watch W negedges, report tone rises, last-high index
  task automatic watch_burst(input int w, output int rises, output int last_hi,
                             output int max_hi);
    logic prev;
    int run;
    prev = tone_out; rises = 0; last_hi = 0; max_hi = 0; run = 0;
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      if (tone_out && !prev) rises++;
      if (tone_out) begin last_hi = i; run++; if (run > max_hi) max_hi = run; end
      else run = 0;
      prev = tone_out;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model = 0;
    chk_disp("R1 reset display");
    chk(!ovf_pulse && !tone_out, "R1 reset outputs", {ovf_pulse, tone_out}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_disp("R1 after release");
    chk(!tone_out, "R1 tone low", tone_out, 0);
  endtask

  task automatic t_count();
    int k;
    strobes(1, k); chk_disp("R2 single strobe");
    strobes(8, k); chk_disp("R2 run to 9");
    strobes(1, k); chk_disp("R2 carry 9 to 10");
    for (int i = 0; i < 5; i++) begin
      strobes(1, k);
      repeat (i) @(negedge clk);
    end
    chk_disp("R2 gapped strobes");
    chk(k == 0, "R2 no overflow early", k, 0);
  endtask

  task automatic t_hold();
    repeat (12) @(negedge clk);
    chk_disp("R3 hold");
  endtask

  task automatic t_segments();
    int k;
    for (int d = 0; d < 10; d++) begin
      chk(segh_ones == lit(model % 10) && seg_ones == ~segh_ones,
          "R9 polarity", {segh_ones, seg_ones}, {lit(model % 10), ~lit(model % 10)});
      strobes(1, k);
    end
  endtask

  task automatic t_overflow_burst();
    int k, r, lh, mh;
    strobes(99 - model, k);
    chk_disp("R4 at 99");
    strobes(1, k);
    chk(k == 1 && ovf_pulse, "R4 pulse", k, 1);
    chk_disp("R4 back to 00");
    watch_burst(BURST_CLKS + 40, r, lh, mh);
    chk(r == BH / 2, "R5 tone rises", r, BH / 2);
    chk(mh == HD, "R5 half period", mh, HD);
    chk(lh == BURST_CLKS, "R6 burst end", lh, BURST_CLKS);
    chk(!tone_out, "R6 idle low", tone_out, 0);
  endtask

  task automatic t_tick_gate();
    int k, r, lh, mh;
    logic held;
    strobes(100, k);
    chk(k == 1, "R4 second overflow", k, 1);
    repeat (9) @(negedge clk);
    ref_tick = 1'b0;
    held = tone_out;
    repeat (30) @(negedge clk);
    chk(tone_out == held, "R8 frozen", tone_out, held);
    ref_tick = 1'b1;
    watch_burst(BURST_CLKS, r, lh, mh);
    // indices counted from 40 negedges after ovf
    chk(lh + 39 == BURST_CLKS + 30, "R8 end delayed", lh + 39, BURST_CLKS + 30);
  endtask

  task automatic t_restart();
    int k, r, lh, mh;
    strobes(100, k);
    repeat (60) @(negedge clk);
    strobes(100, k);
    chk(k == 1, "R7 overflow mid burst", k, 1);
    watch_burst(BURST_CLKS + 40, r, lh, mh);
    chk(lh == BURST_CLKS, "R7 restarted length", lh, BURST_CLKS);
    chk(r == BH / 2, "R7 restarted rises", r, BH / 2);
  endtask

  task automatic t_reset_burst();
    int k;
    strobes(100, k);
    strobes(7, k);
    repeat (6) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    model = 0;
    chk(!tone_out, "R10 tone cleared", tone_out, 0);
    chk_disp("R10 count cleared");
    repeat (50) @(negedge clk);
    chk(!tone_out, "R10 stays low", tone_out, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_disp("R10 after release");
  endtask

  initial begin
    t_reset();
    t_count();
    t_hold();
    t_segments();
    t_overflow_burst();
    t_tick_gate();
    t_restart();
    t_reset_burst();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule